// File: doc/BRIEF.md
# NAND Small-Page Read Address Sequencer

This block turns a linear byte address into the byte sequence that starts a page read on a small-page NAND device: one command byte followed by the address bytes. Such a device has 512-byte main pages with a 16-byte spare area, 32 pages per block and 4096 blocks. The 26-bit byte address therefore splits into a 9-bit column, a 5-bit page-in-block and a 12-bit block number.

The bus carries 8 bits per cycle, so the top column bit (A8) cannot travel in the first address byte. That byte carries only A0..A7. A8 instead picks which half-page read command is issued. Devices of 32 MB or less need only the bits up to A24 and take 3 address bytes. A 64 MB device also needs A25 and takes 4 address bytes. A capacity-select input, sampled when a request is accepted, picks the format.

The block accepts one request at a time through a valid/ready pair and only when idle. It emits the bytes on a valid/ready byte stream. Each byte is tagged as command or address, and the final address byte is flagged. A downstream strobe generator consumes the stream.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, out_valid is 0 and req_ready is 1.
- R2: req_ready is 1 only while idle. A request is accepted when req_valid and req_ready are both 1. While a sequence is in progress, req_valid, req_addr and req_long have no effect on the emitted bytes.
- R3: In the cycle after acceptance, out_valid is 1 with out_is_addr = 0 (command tag). The byte is 0x00 when A8 = 0 and 0x01 when A8 = 1. A8 is never sent as an address byte.
- R4: The first address byte (out_is_addr = 1) equals A[7:0].
- R5: The second address byte equals A[16:9]. The third equals A[24:17].
- R6: When req_long was 1 at acceptance, a fourth address byte follows, equal to {7'b0, A[25]}. When it was 0, exactly three address bytes are sent and A[25] appears nowhere.
- R7: out_last is 1 only on the final address byte of a sequence, and never on the command byte.
- R8: While out_valid is 1 and out_ready is 0, out_byte, out_is_addr and out_last hold their values and out_valid stays 1.
- R9: After the final byte is handshaken, the next cycle has out_valid = 0 and req_ready = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 26 | Linear byte address (A25..A0) |
| req_long | input | 1 | 1 selects the 4-address-byte format, 0 the 3-byte format |
| req_ready | output | 1 | Sequencer idle and able to accept |
| out_valid | output | 1 | Stream byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_byte | output | 8 | Command or address byte |
| out_is_addr | output | 1 | 1 = address byte, 0 = command byte |
| out_last | output | 1 | Final address byte of the sequence |

## Verification
A wrong slot counter shows up on the very next handshake. The consumer sees a byte that does not match the address field expected at that position, out_last lands on the wrong byte, or a fourth byte appears in short mode. A corrupted state register shows as req_ready asserted while out_valid is high, or as a missing command byte in the cycle after acceptance. A request register that is overwritten while busy changes the remaining address bytes within one cycle. Random stalls on out_ready expose any byte that moves while it is being held.

// File: rtl/nas_pkg.sv
package nas_pkg;

    localparam int COL_W     = 9;
    localparam int PAGE_W    = 5;
    localparam int BLK_W     = 12;
    localparam int BUS_W     = 8;
    localparam int LIN_W     = COL_W + PAGE_W + BLK_W;
    localparam int ROW_W     = PAGE_W + BLK_W;
    localparam int SHORT_CYC = 3;
    localparam int LONG_CYC  = 4;
    localparam int ROW_BYTES = LONG_CYC - 1;
    localparam int ROW_PAD_W = ROW_BYTES * BUS_W;
    localparam int SLOT_W    = $clog2(LONG_CYC + 1);

    localparam logic [BUS_W-1:0] CMD_READ_LO = 8'h00;
    localparam logic [BUS_W-1:0] CMD_READ_HI = 8'h01;

    typedef enum logic {
        TAG_CMD  = 1'b0,
        TAG_ADDR = 1'b1
    } tag_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_ADDR = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic [BLK_W-1:0]  blk;
        logic [PAGE_W-1:0] pg;
        logic              half;
        logic [COL_W-2:0]  col_lo;
    } nand_addr_t;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        tag_e             tag;
        logic             last;
    } out_beat_t;

    function automatic nand_addr_t split_addr(input logic [LIN_W-1:0] a);
        nand_addr_t f;
        f.col_lo = a[COL_W-2:0];
        f.half   = a[COL_W-1];
        f.pg     = a[COL_W +: PAGE_W];
        f.blk    = a[COL_W+PAGE_W +: BLK_W];
        return f;
    endfunction

    function automatic logic [BUS_W-1:0] read_cmd(input logic half);
        return half ? CMD_READ_HI : CMD_READ_LO;
    endfunction

    function automatic logic [SLOT_W-1:0] final_slot(input logic long_fmt);
        return long_fmt ? SLOT_W'(LONG_CYC) : SLOT_W'(SHORT_CYC);
    endfunction

endpackage

// File: rtl/nas_addr_split.sv
module nas_addr_split
    import nas_pkg::*;
(
    input  logic [LIN_W-1:0]     lin_addr,
    output nand_addr_t           fields,
    output logic [ROW_PAD_W-1:0] row_pad
);
    logic [ROW_W-1:0] row;

    always_comb begin
        fields  = split_addr(lin_addr);
        row     = {fields.blk, fields.pg};
        row_pad = ROW_PAD_W'(row);
    end
endmodule

// File: rtl/nas_byte_mux.sv
module nas_byte_mux
    import nas_pkg::*;
(
    input  nand_addr_t           fields,
    input  logic [ROW_PAD_W-1:0] row_pad,
    input  logic [SLOT_W-1:0]    slot,
    input  logic                 long_fmt,
    output out_beat_t            beat
);
    logic [BUS_W-1:0] addr_b [LONG_CYC];

    genvar g;
    generate
        for (g = 0; g < LONG_CYC; g++) begin : g_addr_byte
            if (g == 0) begin : g_col
                assign addr_b[g] = fields.col_lo;
            end else begin : g_row
                assign addr_b[g] = row_pad[(g-1)*BUS_W +: BUS_W];
            end
        end
    endgenerate

    always_comb begin
        beat.data = read_cmd(fields.half);
        beat.tag  = TAG_CMD;
        beat.last = 1'b0;
        if (slot != '0) begin
            beat.tag  = TAG_ADDR;
            beat.data = '0;
            for (int i = 0; i < LONG_CYC; i++) begin
                if (slot == SLOT_W'(i + 1)) begin
                    beat.data = addr_b[i];
                end
            end
            beat.last = (slot == final_slot(long_fmt));
        end
    end
endmodule

// File: rtl/nas_seq_ctrl.sv
module nas_seq_ctrl
    import nas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_long,
    input  logic              out_ready,
    output logic              req_ready,
    output logic              req_take,
    output logic              out_valid,
    output logic [SLOT_W-1:0] slot,
    output logic              long_fmt
);
    seq_st_e           st_q, st_d;
    logic [SLOT_W-1:0] slot_d;
    logic              long_d;

    assign req_ready = (st_q == ST_IDLE);
    assign req_take  = req_ready && req_valid;
    assign out_valid = (st_q != ST_IDLE);

    always_comb begin
        st_d   = st_q;
        slot_d = slot;
        long_d = long_fmt;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    st_d   = ST_CMD;
                    slot_d = '0;
                    long_d = req_long;
                end
            end
            ST_CMD: begin
                if (out_ready) begin
                    st_d   = ST_ADDR;
                    slot_d = SLOT_W'(1);
                end
            end
            ST_ADDR: begin
                if (out_ready) begin
                    if (slot == final_slot(long_fmt)) begin
                        st_d   = ST_IDLE;
                        slot_d = '0;
                    end else begin
                        slot_d = slot + SLOT_W'(1);
                    end
                end
            end
            default: begin
                st_d   = ST_IDLE;
                slot_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            slot     <= '0;
            long_fmt <= 1'b0;
        end else begin
            st_q     <= st_d;
            slot     <= slot_d;
            long_fmt <= long_d;
        end
    end
endmodule

// File: rtl/nand_addr_seq.sv
module nand_addr_seq
    import nas_pkg::*;
#(
    parameter int ADDR_W = nas_pkg::LIN_W,
    parameter int DATA_W = nas_pkg::BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_long,
    output logic              req_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_byte,
    output logic              out_is_addr,
    output logic              out_last
);
    logic [LIN_W-1:0]     addr_q;
    logic                 take;
    logic [SLOT_W-1:0]    slot;
    logic                 long_fmt;
    nand_addr_t           fields;
    logic [ROW_PAD_W-1:0] row_pad;
    out_beat_t            beat;

    nas_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_long  (req_long),
        .out_ready (out_ready),
        .req_ready (req_ready),
        .req_take  (take),
        .out_valid (out_valid),
        .slot      (slot),
        .long_fmt  (long_fmt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (take) begin
            addr_q <= LIN_W'(req_addr);
        end
    end

    nas_addr_split u_split (
        .lin_addr (addr_q),
        .fields   (fields),
        .row_pad  (row_pad)
    );

    nas_byte_mux u_mux (
        .fields   (fields),
        .row_pad  (row_pad),
        .slot     (slot),
        .long_fmt (long_fmt),
        .beat     (beat)
    );

    assign out_byte    = DATA_W'(beat.data);
    assign out_is_addr = (beat.tag == TAG_ADDR);
    assign out_last    = beat.last;
endmodule

// File: rtl/nas_checker.sv
module nas_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [25:0] req_addr,
    input logic        req_long,
    input logic        req_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [7:0]  out_byte,
    input logic        out_is_addr,
    input logic        out_last
);
    logic       half_q;
    logic       long_q;
    logic [2:0] addr_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q    <= 1'b0;
            long_q    <= 1'b0;
            addr_seen <= '0;
        end else if (req_valid && req_ready) begin
            half_q    <= req_addr[8];
            long_q    <= req_long;
            addr_seen <= '0;
        end else if (out_valid && out_ready && out_is_addr) begin
            addr_seen <= addr_seen + 3'd1;
        end
    end

    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready);

    a_r3_cmd_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (out_valid && !out_is_addr));

    a_r3_cmd_value: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_addr) |-> (out_byte == {7'b0, half_q}));

    a_r3_cmd_then_addr: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_addr && out_ready) |=> (out_valid && out_is_addr));

    a_r6_addr_count: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> (addr_seen == (long_q ? 3'd3 : 3'd2)));

    a_r7_last_is_addr: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> out_is_addr);

    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)
            && $stable(out_is_addr) && $stable(out_last)));

    a_r9_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> (!out_valid && req_ready));
endmodule

bind nand_addr_seq nas_checker u_nas_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_long    (req_long),
    .req_ready   (req_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_byte    (out_byte),
    .out_is_addr (out_is_addr),
    .out_last    (out_last)
);

// File: tb/nand_addr_seq_tb.sv
module nand_addr_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [25:0] req_addr = '0;
    logic        req_long = 1'b0;
    logic        req_ready;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;
    logic        out_is_addr;
    logic        out_last;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_addr_seq dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_long    (req_long),
        .req_ready   (req_ready),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_byte    (out_byte),
        .out_is_addr (out_is_addr),
        .out_last    (out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic [25:0] a, input int k);
        case (k)
            0: return {7'b0, a[8]};
            1: return a[7:0];
            2: return a[16:9];
            3: return a[24:17];
            default: return {7'b0, a[25]};
        endcase
    endfunction

    function automatic string slot_req(input int k);
        case (k)
            0: return "R3";
            1: return "R4";
            2, 3: return "R5";
            default: return "R6";
        endcase
    endfunction

    // stall_pct: chance of out_ready low; junk: drive other requests while busy
    task automatic run_seq(input logic [25:0] a, input logic lng,
                           input int stall_pct, input bit junk);
        int n;
        int k;
        logic [7:0] held;
        bit stalled;
        n = lng ? 4 : 3;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_long  = lng;
        out_ready = 1'b0;
        @(negedge clk);
        // R3: command byte present in the cycle after acceptance
        chk(out_valid == 1'b1, "R3", int'(out_valid), 1);
        chk(out_is_addr == 1'b0, "R3", int'(out_is_addr), 0);
        k = 0;
        stalled = 1'b0;
        held = '0;
        while (k <= n) begin
            if (junk) begin
                req_valid = 1'b1;
                req_addr  = 26'($urandom);
                req_long  = 1'($urandom);
            end else begin
                req_valid = 1'b0;
                req_long  = 1'($urandom);
            end
            chk(out_valid == 1'b1 && req_ready == 1'b0, "R2",
                int'({out_valid, req_ready}), 2);
            chk(out_byte == exp_byte(a, k), slot_req(k), int'(out_byte), int'(exp_byte(a, k)));
            chk(out_is_addr == (k != 0), (k == 0) ? "R3" : "R4",
                int'(out_is_addr), int'(k != 0));
            chk(out_last == (k == n), "R7", int'(out_last), int'(k == n));
            if (stalled) chk(out_byte == held, "R8", int'(out_byte), int'(held));
            out_ready = ($urandom_range(99) >= stall_pct) ? 1'b1 : 1'b0;
            stalled = !out_ready;
            held = out_byte;
            @(negedge clk);
            if (!stalled) k++;
        end
        out_ready = 1'b0;
        req_valid = 1'b0;
        // R9 / R6: idle right after final handshake, no extra byte
        chk(out_valid == 1'b0, "R6", int'(out_valid), 0);
        chk(req_ready == 1'b1, "R9", int'(req_ready), 1);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(req_ready == 1'b1, "R1", int'(req_ready), 1);

        run_seq(26'h000_0000, 1'b0, 0, 1'b0);    // R3 A8=0 gives 0x00
        run_seq(26'h000_0100, 1'b0, 0, 1'b0);    // R3 A8=1 gives 0x01
        run_seq(26'h3FF_FFFF, 1'b0, 30, 1'b0);   // R6 A25 dropped in short mode
        run_seq(26'h200_0000, 1'b1, 30, 1'b0);   // R6 A25 in fourth byte
        run_seq(26'h155_5AA5, 1'b1, 50, 1'b1);   // R2 busy requests ignored
        run_seq(26'h0AA_A15A, 1'b0, 50, 1'b1);   // R2 / R9
        run_seq(26'h1FE_01FF, 1'b1, 80, 1'b0);   // R8 heavy stalls

        for (int i = 0; i < 200; i++) begin
            run_seq(26'($urandom), 1'($urandom), int'($urandom_range(60)), 1'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule